// File: doc/BRIEF.md
# Stack Pointer and Context Stacking Unit

This block keeps the stack pointer of a small 8-bit processor and drives the byte-wide stack memory traffic. The pointer always names the next free stack byte. It moves down by one for every byte stored and up by one for every byte fetched. The range is set by two parameters, an upper address and a lower address. Leaving the range at either end wraps the pointer to the other end with no flag. The upper bits of the pointer are constant for a given build. They are taken from the upper address parameter.

A request is taken only while the unit is idle. It starts a sequence of one to nine memory accesses, one access per clock, and `busy` is high for that whole sequence. The sequences are:
- a single byte store or fetch;
- a subroutine return address of two or three bytes, stored or fetched;
- a nine-byte interrupt frame, stored or fetched.

Stored bytes are presented on a write strobe with address and data. Fetches use a read strobe and expect the memory to return the byte in the same cycle. Fetched bytes are collected and shown on the restored-register outputs, and `rd_done` pulses once the last one has arrived.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset, and after a stack-reset command taken while idle, `sp` equals SP_MAX. The stack-reset command wins over every other request given in the same cycle.
- R2: A single store writes `push_data` at address `sp` in the cycle after the request, then `sp` drops by one.
- R3: A single fetch reads at address `sp`+1 in the cycle after the request. `sp` then holds that address, and the byte read appears on `pop_data`.
- R4: A store made while `sp` equals SP_MIN writes at SP_MIN and leaves `sp` at SP_MAX. No status output reports this.
- R5: A fetch made while `sp` equals SP_MAX reads at SP_MIN and leaves `sp` at SP_MIN.
- R6: The upper HI_W bits of `sp` always equal the upper HI_W bits of SP_MAX.
- R7: A call request stores the program counter starting with bits 7:0 at `sp`. It then stores bits 15:8, and then bits 23:16 only when `call_long` is 1.
- R8: A return request fetches two bytes, or three when `ret_long` is 1. `pc_out` then holds the address saved by the matching call, and `pc_out[23:16]` is 0 after a two-byte return.
- R9: An interrupt request stores nine bytes in nine consecutive cycles at descending addresses. The order is PC[7:0], PC[15:8], PC[23:16], Y[7:0], Y[15:8], X[7:0], X[15:8], A, CC.
- R10: An interrupt-return request fetches nine bytes in the exact reverse of the R9 order, starting with CC at `sp`+1. It then presents PC, X, Y, A and CC on the restored outputs and pulses `rd_done` for one cycle.
- R11: While `busy` is high, every new request is ignored. No extra memory access occurs and `sp` moves only as the running sequence dictates.
- R12: Requests given together are served in this order: stack reset, interrupt, interrupt return, call, return, store, fetch.
- R13: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stk_rst | input | 1 | Stack-reset command |
| push_req | input | 1 | Single byte store request |
| push_data | input | 8 | Byte to store |
| pop_req | input | 1 | Single byte fetch request |
| call_req | input | 1 | Save return address |
| call_long | input | 1 | Call saves three bytes instead of two |
| ret_req | input | 1 | Restore return address |
| ret_long | input | 1 | Return fetches three bytes instead of two |
| irq_req | input | 1 | Save interrupt frame |
| iret_req | input | 1 | Restore interrupt frame |
| pc_in | input | 24 | Program counter to save |
| x_in | input | 16 | X index register to save |
| y_in | input | 16 | Y index register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, valid in the strobe cycle |
| pop_data | output | 8 | Last fetched byte |
| pc_out | output | 24 | Restored program counter |
| x_out | output | 16 | Restored X |
| y_out | output | 16 | Restored Y |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |
| rd_done | output | 1 | One-cycle pulse after a fetch sequence completes |

## Verification
The assertions assume that the stack memory returns read data in the same cycle as the read strobe. They also assume that SP_MIN and SP_MAX share their upper HI_W bits, so that every address the pointer steps through lies inside that window. The wrap properties further rely on `sp` changing only through accesses or the stack-reset command. The bench meets these conditions in three ways. Its byte model reads combinationally. It keeps the default 128-byte window. It raises requests only on falling edges, clearing them after one cycle, except in the test that deliberately holds requests high during a busy sequence.

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter logic [15:0] SP_MAX = 16'h03FF,
  parameter logic [15:0] SP_MIN = 16'h0380,
  parameter int          HI_W   = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stk_rst,
  input  logic        push_req,
  input  logic [7:0]  push_data,
  input  logic        pop_req,
  input  logic        call_req,
  input  logic        call_long,
  input  logic        ret_req,
  input  logic        ret_long,
  input  logic        irq_req,
  input  logic        iret_req,
  input  logic [23:0] pc_in,
  input  logic [15:0] x_in,
  input  logic [15:0] y_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  cc_in,
  output logic [15:0] sp,
  output logic        busy,
  output logic        mem_we,
  output logic        mem_re,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  pop_data,
  output logic [23:0] pc_out,
  output logic [15:0] x_out,
  output logic [15:0] y_out,
  output logic [7:0]  a_out,
  output logic [7:0]  cc_out,
  output logic        rd_done
);
  localparam int LO_W  = 16 - HI_W;
  localparam int FRM_B = 9;
  localparam int FRM_W = 8 * FRM_B;
  localparam int CNT_W = $clog2(FRM_B + 1);

  localparam logic [LO_W-1:0] LO_MAX = SP_MAX[LO_W-1:0];
  localparam logic [LO_W-1:0] LO_MIN = SP_MIN[LO_W-1:0];
  localparam logic [LO_W-1:0] LO_ONE = {{(LO_W-1){1'b0}}, 1'b1};

  logic [LO_W-1:0]  lo_q, lo_dec, lo_inc;
  logic [CNT_W-1:0] cnt_q, n_cnt;
  logic             rd_q, n_rd, go;
  logic [FRM_W-1:0] wbuf_q, rbuf_q, n_wbuf;

  assign lo_dec = (lo_q == LO_MIN) ? LO_MAX : lo_q - LO_ONE;
  assign lo_inc = (lo_q == LO_MAX) ? LO_MIN : lo_q + LO_ONE;

  assign sp        = {SP_MAX[15:LO_W], lo_q};
  assign busy      = (cnt_q != '0);
  assign mem_we    = busy & ~rd_q;
  assign mem_re    = busy & rd_q;
  assign mem_addr  = rd_q ? {SP_MAX[15:LO_W], lo_inc} : sp;
  assign mem_wdata = wbuf_q[7:0];

  assign pop_data = rbuf_q[7:0];
  assign pc_out   = rbuf_q[23:0];
  assign y_out    = rbuf_q[39:24];
  assign x_out    = rbuf_q[55:40];
  assign a_out    = rbuf_q[63:56];
  assign cc_out   = rbuf_q[71:64];

  always_comb begin
    go     = 1'b0;
    n_cnt  = '0;
    n_rd   = 1'b0;
    n_wbuf = '0;
    if (!busy && !stk_rst) begin
      if (irq_req) begin
        go     = 1'b1;
        n_cnt  = CNT_W'(FRM_B);
        n_wbuf = {cc_in, a_in, x_in, y_in, pc_in};
      end else if (iret_req) begin
        go    = 1'b1;
        n_cnt = CNT_W'(FRM_B);
        n_rd  = 1'b1;
      end else if (call_req) begin
        go     = 1'b1;
        n_cnt  = call_long ? CNT_W'(3) : CNT_W'(2);
        n_wbuf = {{(FRM_W-24){1'b0}}, pc_in};
      end else if (ret_req) begin
        go    = 1'b1;
        n_cnt = ret_long ? CNT_W'(3) : CNT_W'(2);
        n_rd  = 1'b1;
      end else if (push_req) begin
        go     = 1'b1;
        n_cnt  = CNT_W'(1);
        n_wbuf = {{(FRM_W-8){1'b0}}, push_data};
      end else if (pop_req) begin
        go    = 1'b1;
        n_cnt = CNT_W'(1);
        n_rd  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= LO_MAX;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= busy && rd_q && (cnt_q == CNT_W'(1));
      if (!busy && stk_rst) begin
        lo_q <= LO_MAX;
      end else if (go) begin
        cnt_q  <= n_cnt;
        rd_q   <= n_rd;
        wbuf_q <= n_wbuf;
        if (n_rd) rbuf_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (rd_q) begin
          lo_q   <= lo_inc;
          rbuf_q <= {rbuf_q[FRM_W-9:0], mem_rdata};
        end else begin
          lo_q   <= lo_dec;
          wbuf_q <= {8'h00, wbuf_q[FRM_W-1:8]};
        end
      end
    end
  end
endmodule

// File: rtl/stk_ptr_unit_chk.sv
module stk_ptr_unit_chk #(
  parameter logic [15:0] SP_MAX = 16'h03FF,
  parameter logic [15:0] SP_MIN = 16'h0380
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stk_rst,
  input logic        busy,
  input logic [15:0] sp,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr
);
  p_stkrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stk_rst) |=> (sp == SP_MAX && !busy));

  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && sp != SP_MIN) |=> (sp == $past(sp) - 16'd1));

  p_pop_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && sp != SP_MAX) |-> (mem_addr == sp + 16'd1));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp == $past(mem_addr)));

  p_push_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && sp == SP_MIN) |=> (sp == SP_MAX));

  p_pop_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && sp == SP_MAX) |=> (sp == SP_MIN));

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(.SP_MAX(SP_MAX), .SP_MIN(SP_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .stk_rst(stk_rst), .busy(busy), .sp(sp),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/stk_ptr_unit_tb.sv
module stk_ptr_unit_tb;
  localparam int CLK_PER = 10;
  localparam logic [15:0] SMAX = 16'h03FF;
  localparam logic [15:0] SMIN = 16'h0380;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stk_rst = 0, push_req = 0, pop_req = 0, call_req = 0, call_long = 0;
  logic ret_req = 0, ret_long = 0, irq_req = 0, iret_req = 0;
  logic [7:0]  push_data = 0, a_in = 0, cc_in = 0;
  logic [23:0] pc_in = 0;
  logic [15:0] x_in = 0, y_in = 0;
  logic [15:0] sp, mem_addr, x_out, y_out;
  logic        busy, mem_we, mem_re, rd_done;
  logic [7:0]  mem_wdata, mem_rdata, pop_data, a_out, cc_out;
  logic [23:0] pc_out;

  logic [7:0] mem [0:127];
  int n_cmp = 0, n_bad = 0;
  int acc_cyc;
  logic [15:0] first_addr;
  logic first_we, first_re;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[6:0]];

  stk_ptr_unit #(.SP_MAX(SMAX), .SP_MIN(SMIN), .HI_W(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .stk_rst(stk_rst), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .call_req(call_req), .call_long(call_long), .ret_req(ret_req),
    .ret_long(ret_long), .irq_req(irq_req), .iret_req(iret_req), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .a_in(a_in), .cc_in(cc_in), .sp(sp), .busy(busy),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pop_data(pop_data), .pc_out(pc_out), .x_out(x_out),
    .y_out(y_out), .a_out(a_out), .cc_out(cc_out), .rd_done(rd_done)
  );

  // {op (0 store, 1 fetch), data, sp after, fetched byte}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'hA1, 16'h03FE, 8'h00},
    {1'b0, 8'hB2, 16'h03FD, 8'h00},
    {1'b0, 8'hC3, 16'h03FC, 8'h00},
    {1'b1, 8'h00, 16'h03FD, 8'hC3},
    {1'b1, 8'h00, 16'h03FE, 8'hB2},
    {1'b0, 8'hD4, 16'h03FD, 8'h00},
    {1'b1, 8'h00, 16'h03FE, 8'hD4},
    {1'b1, 8'h00, 16'h03FF, 8'hA1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    stk_rst = 0; push_req = 0; pop_req = 0; call_req = 0;
    ret_req = 0; irq_req = 0; iret_req = 0;
  endtask

  // Called at a falling edge with request lines already set.
  task automatic run_op();
    @(posedge clk);
    @(negedge clk);
    clear_reqs();
    first_addr = mem_addr; first_we = mem_we; first_re = mem_re;
    acc_cyc = 0;
    while (busy) begin
      acc_cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_bad++;
    $display("FAIL R11 watchdog expired actual=busy expected=idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] prev_sp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset sp", sp, SMAX);
    check("R1 reset busy", busy, 0);
    check("R13 reset strobes", {mem_we, mem_re}, 0);

    prev_sp = SMAX;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][32]) pop_req = 1;
      else begin push_req = 1; push_data = VEC[i][31:24]; end
      run_op();
      if (VEC[i][32]) begin
        check("R3 fetch addr", first_addr, VEC[i][23:8]);
        check("R3 fetch sp", sp, VEC[i][23:8]);
        check("R3 fetch data", pop_data, VEC[i][7:0]);
      end else begin
        check("R2 store addr", first_addr, prev_sp);
        check("R2 store strobe", first_we, 1);
        check("R2 store sp", sp, VEC[i][23:8]);
        check("R2 store mem", mem[prev_sp[6:0]], VEC[i][31:24]);
      end
      prev_sp = VEC[i][23:8];
    end

    for (int i = 0; i < 127; i++) begin
      push_req = 1; push_data = 8'(i) ^ 8'hA5;
      run_op();
    end
    check("R4 reach min", sp, SMIN);
    check("R6 upper bits at min", sp[15:7], SMAX[15:7]);
    push_req = 1; push_data = 8'hEE;
    run_op();
    check("R4 wrap addr", first_addr, SMIN);
    check("R4 wrap sp", sp, SMAX);
    check("R4 wrap mem", mem[SMIN[6:0]], 8'hEE);
    pop_req = 1;
    run_op();
    check("R5 wrap addr", first_addr, SMIN);
    check("R5 wrap sp", sp, SMIN);
    check("R5 wrap data", pop_data, 8'hEE);

    stk_rst = 1; push_req = 1; irq_req = 1;
    @(posedge clk); @(negedge clk); clear_reqs();
    check("R1 stk_rst sp", sp, SMAX);
    check("R12 stk_rst wins", busy, 0);

    pc_in = 24'h123456; call_req = 1; call_long = 0;
    run_op();
    check("R7 short call len", acc_cyc, 2);
    check("R7 short call sp", sp, 16'h03FD);
    check("R7 short call bytes", {mem[7'h7E], mem[7'h7F]}, 16'h3456);
    pc_in = 0; ret_req = 1; ret_long = 0;
    run_op();
    check("R8 short ret pc", pc_out, 24'h003456);
    check("R8 short ret sp", sp, SMAX);
    check("R10 rd_done after ret", rd_done, 1);

    pc_in = 24'h123456; call_req = 1; call_long = 1;
    run_op();
    check("R7 long call bytes", {mem[7'h7D], mem[7'h7E], mem[7'h7F]}, 24'h123456);
    check("R7 long call sp", sp, 16'h03FC);
    ret_req = 1; ret_long = 1;
    run_op();
    check("R8 long ret pc", pc_out, 24'h123456);
    check("R8 long ret sp", sp, SMAX);

    pc_in = 24'hABCDEF; y_in = 16'h1122; x_in = 16'h3344; a_in = 8'h55; cc_in = 8'h66;
    irq_req = 1; iret_req = 1; call_req = 1;
    @(posedge clk); @(negedge clk); clear_reqs();
    acc_cyc = 0;
    push_req = 1; push_data = 8'h77; pop_req = 1; ret_req = 1;
    while (busy) begin acc_cyc++; @(negedge clk); end
    clear_reqs();
    check("R9 irq length", acc_cyc, 9);
    check("R11 sp after ignored reqs", sp, 16'h03F6);
    check("R11 untouched byte", mem[7'h76], 8'hAC);
    check("R9 frame pc", {mem[7'h7D], mem[7'h7E], mem[7'h7F]}, 24'hABCDEF);
    check("R9 frame y", {mem[7'h7B], mem[7'h7C]}, 16'h1122);
    check("R9 frame x", {mem[7'h79], mem[7'h7A]}, 16'h3344);
    check("R9 frame a cc", {mem[7'h78], mem[7'h77]}, 16'h5566);
    check("R12 irq over iret and call", mem[7'h7F], 8'hEF);

    iret_req = 1; call_req = 1; push_req = 1;
    run_op();
    check("R10 first fetch at cc", first_addr, 16'h03F7);
    check("R10 length", acc_cyc, 9);
    check("R10 pc", pc_out, 24'hABCDEF);
    check("R10 y", y_out, 16'h1122);
    check("R10 x", x_out, 16'h3344);
    check("R10 a", a_out, 8'h55);
    check("R10 cc", cc_out, 8'h66);
    check("R10 rd_done", rd_done, 1);
    check("R10 sp", sp, SMAX);
    @(negedge clk);
    check("R10 rd_done one cycle", rd_done, 0);

    push_req = 1; pop_req = 1; push_data = 8'h3C;
    run_op();
    check("R12 store over fetch", {first_we, first_re}, 2'b10);
    check("R12 store sp", sp, 16'h03FE);
    pop_req = 1;
    run_op();
    check("R3 fetch back", pop_data, 8'h3C);
    check("R6 upper bits", sp[15:7], SMAX[15:7]);
    check("R13 idle strobes", {mem_we, mem_re}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule